// File: doc/BRIEF.md
# Double-Word Pair Load/Store Sequencer

This block carries out one double-word memory instruction as two single-word memory transactions to adjacent word addresses. A start strobe supplies the base register value, a signed 16-bit displacement, an even register number and a load/store select. The sequencer works out a word-aligned address, issues two requests on a simple request/ready memory port and moves data between memory and a register pair.

The register pair is cross-mapped. The odd register of the pair belongs to the lower address and the even register to the word above it. Loads return data through two register-file write ports, one per beat, in a fixed order. Stores fetch the two registers through one combinational read port. A variant with an implied zero base lets the displacement act as an absolute address. An odd register number is rejected without any memory traffic.

The register write for the last loaded word lands in the same cycle as the completion pulse, so the loaded pair cannot be used by the instruction issued right after it.

Top module: `pair_xfer_seq`

## Requirements
- R1: The first beat's address is the base value plus the sign-extended 16-bit offset, with address bits 1:0 forced to zero. The sum wraps modulo 2^32.
- R2: The second beat's address is the first beat's address plus 4, and it is issued only after the first beat completes. A beat completes on a clock edge where memReq and memReady are both high. Until then memReq stays high and memAddr stays stable.
- R3: On a load (isStore=0), the word returned by the first beat is written to register regIdx+1 through write port A. rfWeA is high for exactly one cycle, the cycle after the first beat completes.
- R4: On a load, the word returned by the second beat is written to register regIdx through write port B. rfWeB is high for exactly one cycle, the cycle after the second beat completes, which is also the done cycle. rfWeA and rfWeB are never high together.
- R5: On a store (isStore=1), memWe is high during both beats. The first beat writes the contents of register regIdx+1, and the second beat writes the contents of register regIdx; both are read through rfRdIdx/rfRdData. No register-file write occurs.
- R6: With zeroBase=1 the base value is ignored and the first address is the sign-extended offset with bits 1:0 cleared.
- R7: If regIdx bit 0 is 1 at start, no memory request is made and no register is written. done and illegalPair pulse together in the cycle after start.
- R8: busy is high from the cycle after an accepted start through the done cycle, and done is a single-cycle pulse. A start seen while busy is ignored: it changes no address, data or beat count.
- R9: While rstN is low and right after reset, memReq, busy, done, illegalPair, rfWeA and rfWeB are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe; accepted only when idle |
| isStore | input | 1 | 1 = store pair, 0 = load pair |
| zeroBase | input | 1 | 1 = treat base as zero |
| baseVal | input | 32 | Base register value |
| offsetVal | input | 16 | Signed displacement |
| regIdx | input | 5 | Even register number of the pair |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegalPair | output | 1 | Pulses with done when regIdx was odd |
| memReq | output | 1 | Memory request valid |
| memAddr | output | 32 | Memory word address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory completes current beat |
| memRdata | input | 32 | Memory read data, valid with memReady |
| rfRdIdx | output | 5 | Register-file read index for stores |
| rfRdData | input | 32 | Register-file read data (combinational) |
| rfWeA | output | 1 | Write port A enable (first loaded word) |
| rfWaddrA | output | 5 | Write port A register number |
| rfWdataA | output | 32 | Write port A data |
| rfWeB | output | 1 | Write port B enable (second loaded word) |
| rfWaddrB | output | 5 | Write port B register number |
| rfWdataB | output | 32 | Write port B data |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, a 16-bit displacement and 32 registers. With these values the sign extension of negative displacements, the wrap of the address sum past 2^32 and pairs at the top of the register range (30/31) can all be driven directly. Memory latency is set separately for each scenario, from zero to several wait cycles. This exercises the hold rule of R2 and the one-cycle-late register writes of R3 and R4 under stalls.

// File: rtl/pair_xfer_pkg.sv
package pair_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_FIN  = 3'd3,
    ST_BAD  = 3'd4
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operands of a new operation
    logic req;      // a memory beat is outstanding
    logic beatHi;   // current beat is the upper word
    logic takeLo;   // first beat completes this edge
    logic takeHi;   // second beat completes this edge
  } pairStrobe_t;

endpackage

// File: rtl/pair_xfer_ctrl.sv
module pair_xfer_ctrl
  import pair_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        regIdxLsb,
  input  logic        memReady,
  output pairStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        illegalPair
);

  seqState_e state, stateNxt;
  logic accept;

  assign accept = startIn && (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (accept) stateNxt = regIdxLsb ? ST_BAD : ST_LO;
      ST_LO:   if (memReady) stateNxt = ST_HI;
      ST_HI:   if (memReady) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      ST_BAD:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.capture = accept;
    strobe.req     = (state == ST_LO) || (state == ST_HI);
    strobe.beatHi  = (state == ST_HI);
    strobe.takeLo  = (state == ST_LO) && memReady;
    strobe.takeHi  = (state == ST_HI) && memReady;
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN) || (state == ST_BAD);
  assign illegalPair = (state == ST_BAD);

  // R7: an odd pair never reaches memory
  assert_odd_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy && regIdxLsb) |=> (illegalPair && done && !strobe.req));

  // R8: done is a single pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy holds until the done cycle
  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R8: a start while busy does not restart the sequence
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startIn) |=> !strobe.capture || !busy);

endmodule

// File: rtl/pair_xfer_dp.sv
module pair_xfer_dp
  import pair_xfer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 16,
  parameter int REG_COUNT = 32,
  localparam int REG_W      = $clog2(REG_COUNT),
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int ALIGN_BITS = $clog2(WORD_BYTES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  pairStrobe_t       strobe,
  input  logic              isStore,
  input  logic              zeroBase,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [OFS_W-1:0]  offsetVal,
  input  logic [REG_W-1:0]  regIdx,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [REG_W-1:0]  rfRdIdx,
  output logic              rfWeA,
  output logic [REG_W-1:0]  rfWaddrA,
  output logic [DATA_W-1:0] rfWdataA,
  output logic              rfWeB,
  output logic [REG_W-1:0]  rfWaddrB,
  output logic [DATA_W-1:0] rfWdataB
);

  logic [ADDR_W-1:0] eaReg, eaSum, baseSel, ofsExt, eaHi;
  logic [REG_W-1:0]  rtReg, rtOdd;
  logic              storeReg;

  // address arithmetic
  assign baseSel = zeroBase ? '0 : baseVal;
  assign ofsExt  = {{(ADDR_W-OFS_W){offsetVal[OFS_W-1]}}, offsetVal};
  assign eaSum   = baseSel + ofsExt;
  assign eaHi    = eaReg + ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaReg    <= '0;
      rtReg    <= '0;
      storeReg <= 1'b0;
    end else if (strobe.capture) begin
      eaReg    <= {eaSum[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      rtReg    <= regIdx;
      storeReg <= isStore;
    end
  end

  assign rtOdd = {rtReg[REG_W-1:1], 1'b1};

  // memory side
  assign memReq   = strobe.req;
  assign memWe    = strobe.req && storeReg;
  assign memAddr  = strobe.beatHi ? eaHi : eaReg;
  assign rfRdIdx  = strobe.beatHi ? rtReg : rtOdd;
  assign memWdata = rfRdData;

  // register-file write side, one registered stage per beat
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rfWeA    <= 1'b0;
      rfWeB    <= 1'b0;
      rfWdataA <= '0;
      rfWdataB <= '0;
    end else begin
      rfWeA <= strobe.takeLo && !storeReg;
      rfWeB <= strobe.takeHi && !storeReg;
      if (strobe.takeLo) rfWdataA <= memRdata;
      if (strobe.takeHi) rfWdataB <= memRdata;
    end
  end

  assign rfWaddrA = rtOdd;
  assign rfWaddrB = rtReg;

  // R1: every beat is word aligned
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ALIGN_BITS-1:0] == '0));

  // R2: a stalled beat holds its request and address
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  // R2: the upper beat follows the lower one, one word higher
  assert_second_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !strobe.beatHi) |=>
      (memReq && memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES)));

  // R4: write ports never fire together
  assert_ports_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWeA && rfWeB));

  // R5: a store never writes the register file
  assert_store_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !(rfWeA || rfWeB));

endmodule

// File: rtl/pair_xfer_seq.sv
module pair_xfer_seq
  import pair_xfer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 16,
  parameter int REG_COUNT = 32,
  localparam int REG_W    = $clog2(REG_COUNT)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              isStore,
  input  logic              zeroBase,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [OFS_W-1:0]  offsetVal,
  input  logic [REG_W-1:0]  regIdx,
  output logic              busy,
  output logic              done,
  output logic              illegalPair,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [REG_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWeA,
  output logic [REG_W-1:0]  rfWaddrA,
  output logic [DATA_W-1:0] rfWdataA,
  output logic              rfWeB,
  output logic [REG_W-1:0]  rfWaddrB,
  output logic [DATA_W-1:0] rfWdataB
);

  pairStrobe_t strobe;

  pair_xfer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .regIdxLsb  (regIdx[0]),
    .memReady   (memReady),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .illegalPair(illegalPair)
  );

  pair_xfer_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFS_W    (OFS_W),
    .REG_COUNT(REG_COUNT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .isStore  (isStore),
    .zeroBase (zeroBase),
    .baseVal  (baseVal),
    .offsetVal(offsetVal),
    .regIdx   (regIdx),
    .memReady (memReady),
    .memRdata (memRdata),
    .rfRdData (rfRdData),
    .memReq   (memReq),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .rfRdIdx  (rfRdIdx),
    .rfWeA    (rfWeA),
    .rfWaddrA (rfWaddrA),
    .rfWdataA (rfWdataA),
    .rfWeB    (rfWeB),
    .rfWaddrB (rfWaddrB),
    .rfWdataB (rfWdataB)
  );

  // R3: a load's first register write follows the completed first beat
  assert_load_write_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !memWe && !strobe.beatHi) |=> rfWeA);

  // R4: the second register write coincides with done
  assert_write_b_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    rfWeB |-> done);

endmodule

// File: tb/pair_xfer_seq_tb.sv
module pair_xfer_seq_tb_top;

  localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;
  localparam logic [31:0] RF_TAG = 32'hCAFE_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0, isStore = 1'b0, zeroBase = 1'b0;
  logic [31:0] baseVal = '0;
  logic [15:0] offsetVal = '0;
  logic [4:0]  regIdx = '0;
  logic        busy, done, illegalPair, memReq, memWe, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData;
  logic [4:0]  rfRdIdx, rfWaddrA, rfWaddrB;
  logic        rfWeA, rfWeB;
  logic [31:0] rfWdataA, rfWdataB;

  always #5 clk = ~clk;

  pair_xfer_seq dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .isStore(isStore),
    .zeroBase(zeroBase), .baseVal(baseVal), .offsetVal(offsetVal),
    .regIdx(regIdx), .busy(busy), .done(done), .illegalPair(illegalPair),
    .memReq(memReq), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData), .rfWeA(rfWeA), .rfWaddrA(rfWaddrA),
    .rfWdataA(rfWdataA), .rfWeB(rfWeB), .rfWaddrB(rfWaddrB),
    .rfWdataB(rfWdataB)
  );

  // memory and register-file models
  assign memRdata = memAddr ^ RD_KEY;
  assign rfRdData = RF_TAG | {27'h0, rfRdIdx};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int latency = 0;
  int waitCnt = 0;
  int hsN = 0;
  logic [31:0] hsAddr [2];
  logic [31:0] hsData [2];
  logic        hsWe   [2];
  int          hsCyc  [2];

  // ready driver: decides at negedge whether the next edge completes a beat
  always @(negedge clk) begin
    if (memReady) begin
      memReady = 1'b0;
      waitCnt  = 0;
    end else if (memReq) begin
      if (waitCnt >= latency) begin
        memReady = 1'b1;
        if (hsN < 2) begin
          hsAddr[hsN] = memAddr;
          hsData[hsN] = memWdata;
          hsWe[hsN]   = memWe;
          hsCyc[hsN]  = cyc + 1;
        end
        hsN = hsN + 1;
      end else begin
        waitCnt = waitCnt + 1;
      end
    end
  end

  // output monitor, sampled shortly after each edge
  int weAN = 0, weBN = 0, doneN = 0, illN = 0;
  int weACyc = 0, weBCyc = 0, doneCyc = 0;
  logic [4:0]  weAAddr, weBAddr;
  logic [31:0] weAData, weBData;
  always @(posedge clk) begin
    #2;
    if (rfWeA) begin weAN++; weACyc = cyc; weAAddr = rfWaddrA; weAData = rfWdataA; end
    if (rfWeB) begin weBN++; weBCyc = cyc; weBAddr = rfWaddrB; weBData = rfWdataB; end
    if (done)  begin doneN++; doneCyc = cyc; end
    if (illegalPair) illN++;
  end

  int nChk = 0, nErr = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expEa(bit zb, logic [31:0] b, logic [15:0] o);
    return ((zb ? 32'h0 : b) + {{16{o[15]}}, o}) & 32'hFFFF_FFFC;
  endfunction

  task automatic clearLogs();
    hsN = 0; weAN = 0; weBN = 0; doneN = 0; illN = 0;
  endtask

  // issue one operation and check everything it produced
  task automatic runOp(bit st, bit zb, logic [31:0] b, logic [15:0] o,
                       logic [4:0] r, int lat, bit poke);
    logic [31:0] ea;
    int startEdge;
    ea = expEa(zb, b, o);
    clearLogs();
    latency = lat;
    @(negedge clk);
    startIn = 1'b1; isStore = st; zeroBase = zb; baseVal = b;
    offsetVal = o; regIdx = r;
    startEdge = cyc + 1;
    @(negedge clk);
    startIn = 1'b0;
    chk("R8 busy after start", {31'h0, busy}, 32'h1);
    if (poke) begin
      startIn = 1'b1; baseVal = b + 32'h100; regIdx = r ^ 5'd2; isStore = ~st;
      @(negedge clk);
      startIn = 1'b0;
      chk("R8 busy while poked", {31'h0, busy}, 32'h1);
    end
    for (int i = 0; i < 200 && doneN == 0; i++) @(negedge clk);
    @(negedge clk);
    chk("R8 idle after done", {31'h0, busy}, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R8 single done", doneN, 1);
    if (r[0]) begin
      chk("R7 no memory beat", hsN, 0);
      chk("R7 illegal pulse", illN, 1);
      chk("R7 done timing", doneCyc, startEdge);
      chk("R7 no reg write", weAN + weBN, 0);
    end else begin
      chk("R2 beat count", hsN, 2);
      chk(zb ? "R6 first address" : "R1 first address", hsAddr[0], ea);
      chk("R2 second address", hsAddr[1], ea + 32'd4);
      chk("R2 beat order", {31'h0, hsCyc[1] > hsCyc[0]}, 32'h1);
      chk("R7 no illegal", illN, 0);
      chk("R4 done timing", doneCyc, hsCyc[1]);
      if (st) begin
        chk("R5 we beat0", {31'h0, hsWe[0]}, 32'h1);
        chk("R5 we beat1", {31'h0, hsWe[1]}, 32'h1);
        chk("R5 data beat0", hsData[0], RF_TAG | {27'h0, r | 5'd1});
        chk("R5 data beat1", hsData[1], RF_TAG | {27'h0, r});
        chk("R5 no reg write", weAN + weBN, 0);
      end else begin
        chk("R3 load we low", {31'h0, hsWe[0] | hsWe[1]}, 32'h0);
        chk("R3 port A count", weAN, 1);
        chk("R3 port A reg", {27'h0, weAAddr}, {27'h0, r | 5'd1});
        chk("R3 port A data", weAData, ea ^ RD_KEY);
        chk("R3 port A timing", weACyc, hsCyc[0]);
        chk("R4 port B count", weBN, 1);
        chk("R4 port B reg", {27'h0, weBAddr}, {27'h0, r});
        chk("R4 port B data", weBData, (ea + 32'd4) ^ RD_KEY);
        chk("R4 port B timing", weBCyc, hsCyc[1]);
      end
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 memReq in reset", {31'h0, memReq}, 32'h0);
    chk("R9 busy in reset", {31'h0, busy}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 done after reset", {31'h0, done | illegalPair}, 32'h0);
    chk("R9 writes after reset", {30'h0, rfWeA, rfWeB}, 32'h0);
  endtask

  task automatic testLoadFast();    runOp(1'b0, 1'b0, 32'h0000_1000, 16'h0012, 5'd4, 0, 1'b0); endtask
  task automatic testLoadStall();   runOp(1'b0, 1'b0, 32'h0000_2003, 16'hFFF5, 5'd10, 3, 1'b0); endtask
  task automatic testStore();       runOp(1'b1, 1'b0, 32'h8000_0040, 16'h7FFF, 5'd30, 1, 1'b0); endtask
  task automatic testZeroBase();    runOp(1'b0, 1'b1, 32'hDEAD_BEEF, 16'h8006, 5'd0, 2, 1'b0); endtask
  task automatic testZeroStore();   runOp(1'b1, 1'b1, 32'h1234_5678, 16'h0101, 5'd2, 0, 1'b0); endtask
  task automatic testWrap();        runOp(1'b0, 1'b0, 32'hFFFF_FFFA, 16'h0006, 5'd6, 1, 1'b0); endtask
  task automatic testOdd();         runOp(1'b0, 1'b0, 32'h0000_4000, 16'h0000, 5'd7, 0, 1'b0); endtask
  task automatic testOddStore();    runOp(1'b1, 1'b0, 32'h0000_4000, 16'h0010, 5'd31, 0, 1'b0); endtask
  task automatic testStartIgnored(); runOp(1'b0, 1'b0, 32'h0000_5000, 16'h0020, 5'd12, 4, 1'b1); endtask

  initial begin
    testReset();
    testLoadFast();
    testLoadStall();
    testStore();
    testZeroBase();
    testZeroStore();
    testWrap();
    testOdd();
    testOddStore();
    testStartIgnored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

endmodule